// File: doc/BRIEF.md
# Centre-aligned dual-slope PWM timer

This block is a counter that climbs from zero to a programmable turn-around value and then falls back to zero, over and over. While it does so it compares its count with one compare value per channel and drives a pulse-width modulated output for each channel. Because each pulse is centred on the turn-around point, all channels share one symmetric time base. Such waveforms suit motor and power-stage control, where edges on different phases must stay centred on each other.

Software programs the block through a small write port. There is a control word that picks where the turn-around value comes from and which channels are inverted. There is a period word, and there is one compare word per channel. Period and compare writes land in holding registers. The counter adopts them only when it sits at zero. This keeps a change of duty or frequency from breaking the symmetry of the cycle in progress. Sticky flags report compare hits and arrival at zero, and a one written to the clear address drops them.

Top module: `symm_pwm_timer`

## Requirements
- R1: A synchronous reset sets the count to 0 with the next step upward. It drives every PWM output and every flag low, clears the control word, and loads all ones into every holding and active period/compare register.
- R2: The counter and the PWM outputs change only on cycles with `tick` high. With `tick` low the count holds, apart from the effect of a control write (R7).
- R3: On each tick the count moves by exactly one. It rises from 0 to TOP, then falls from TOP to 0. TOP and 0 each last one tick, so a full cycle lasts 2*TOP ticks. `falling_o` is 1 while the count is below TOP on the way down, and 0 at 0.
- R4: Control word (address 0): bit 0 = 0 takes TOP from the active period value, and bit 0 = 1 takes it from the active compare value of channel 0. When channel 0 supplies TOP, the period value is ignored.
- R5: Period (address 1) and compare i (address 3+i) writes go to holding registers. On the tick taken at count 0, the holding values become active. They are used for that tick and the whole following cycle, so a write made mid-cycle does not change the cycle in progress.
- R6: A channel's match is a tick where the count equals its active compare value. The match is an up-match at count 0 and at any count reached while rising, including TOP. Otherwise it is a down-match. A non-inverted output is cleared by an up-match and set by a down-match. For compare value c with 0 <= c < TOP, the output is high for 2*c cycles of each 2*TOP cycle window.
- R7: Control bit 1+i inverts channel i. The output becomes the complement of its non-inverted waveform from the cycle after the control write.
- R8: Match flag bit i is set on every tick where channel i matches, and stays set until it is cleared.
- R9: The bottom flag is set on the tick that steps the count from 1 to 0.
- R10: Writing to address 2 clears flags whose data bit is 1 (bit 0 bottom flag, bit 1+i match flag i), and leaves those with a 0 bit unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R11: While channel 0 supplies TOP, `pwm_o[0]` stays low. Its match flag is then set at every TOP.
- R12: TOP may range from 3 to 0xFFFF. At 0xFFFF the count reaches 0xFFFF and turns down to 0xFFFE without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; the counter steps on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 control, 1 period, 2 flag clear, 3+i compare of channel i |
| wr_data | input | WIDTH | Write data |
| pwm_o | output | NCH | PWM output per channel |
| match_flag_o | output | NCH | Sticky compare-match flag per channel |
| bottom_flag_o | output | 1 | Sticky flag for arrival at count 0 |
| cnt_o | output | WIDTH | Current count |
| falling_o | output | 1 | High while the count is descending and above 0 |

## Verification
The bench builds the block with its defaults: a 16-bit count, three channels and a 4-bit address. With three channels, the mode where channel 0 supplies TOP still leaves two live PWM outputs whose duty can be measured against a borrowed TOP. The 16-bit width keeps a single full climb to 0xFFFF within about 65,000 cycles. That makes the largest TOP and its turn without wrap directly observable. Small TOP values, down to the minimum of 3, let duty be counted over complete cycles for both polarities and for compare values at 0 and just below TOP.

// File: rtl/symm_pwm_timer.sv
module symm_pwm_timer #(
  parameter int WIDTH  = 16,
  parameter int NCH    = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    match_flag_o,
  output logic              bottom_flag_o,
  output logic [WIDTH-1:0]  cnt_o,
  output logic              falling_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(3);
  localparam logic [WIDTH-1:0]  ONE    = WIDTH'(1);

  logic             top_sel;
  logic [NCH-1:0]   inv;
  logic [WIDTH-1:0] per_buf, per_act;
  logic [WIDTH-1:0] cmp_buf [NCH];
  logic [WIDTH-1:0] cmp_act [NCH];
  logic [WIDTH-1:0] cnt;
  logic             down;
  logic [NCH-1:0]   raw, mflag, hit;
  logic             bflag;

  wire at_bottom = (cnt == '0);
  wire rising    = at_bottom | ~down;
  wire [WIDTH-1:0] top_now = top_sel ? cmp_act[0] : per_act;
  wire clr_wr    = wr_en && (wr_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_sel <= 1'b0;
      inv     <= '0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      top_sel <= wr_data[0];
      inv     <= wr_data[NCH:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= '1;
      per_act <= '1;
      cnt     <= '0;
      down    <= 1'b0;
      bflag   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_PER) per_buf <= wr_data;
      if (clr_wr && wr_data[0]) bflag <= 1'b0;
      if (tick) begin
        if (at_bottom) begin
          per_act <= per_buf;
          cnt     <= ONE;
          down    <= 1'b0;
        end else if (!down) begin
          if (cnt >= top_now) begin
            cnt  <= cnt - ONE;
            down <= 1'b1;
          end else begin
            cnt  <= cnt + ONE;
          end
        end else begin
          cnt <= cnt - ONE;
          if (cnt == ONE) bflag <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = tick && (cnt == (at_bottom ? cmp_buf[g] : cmp_act[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        cmp_buf[i] <= '1;
        cmp_act[i] <= '1;
      end
      raw   <= '0;
      mflag <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && wr_addr == A_CMP0 + ADDR_W'(i)) cmp_buf[i] <= wr_data;
        if (tick && at_bottom) cmp_act[i] <= cmp_buf[i];
        if (hit[i]) raw[i] <= ~rising;
        if (clr_wr && wr_data[i+1]) mflag[i] <= 1'b0;
        if (hit[i]) mflag[i] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    if (g == 0) begin : g_shared
      assign pwm_o[g] = ~top_sel & (raw[g] ^ inv[g]);
    end else begin : g_plain
      assign pwm_o[g] = raw[g] ^ inv[g];
    end
  end

  assign match_flag_o  = mflag;
  assign bottom_flag_o = bflag;
  assign cnt_o         = cnt;
  assign falling_o     = down & ~at_bottom;

endmodule

// File: rtl/symm_pwm_timer_chk.sv
module symm_pwm_timer_chk #(
  parameter int WIDTH = 16,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [WIDTH-1:0] cnt_o,
  input logic             falling_o,
  input logic [NCH-1:0]   match_flag_o,
  input logic             bottom_flag_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_o));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_o == $past(cnt_o) + ONE) || (cnt_o == $past(cnt_o) - ONE));

  a_r3_leave_bottom: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == '0) |=> (cnt_o == ONE && !falling_o));

  a_r12_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == '1) |=> (falling_o && cnt_o != '0));

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((match_flag_o & $past(match_flag_o)) == $past(match_flag_o)));

  a_r9_bottom_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && falling_o && cnt_o == ONE) |=> bottom_flag_o);

endmodule

bind symm_pwm_timer symm_pwm_timer_chk #(.WIDTH(WIDTH), .NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .cnt_o(cnt_o),
  .falling_o(falling_o), .match_flag_o(match_flag_o), .bottom_flag_o(bottom_flag_o)
);

// File: tb/symm_pwm_timer_tb_top.sv
module symm_pwm_timer_tb_top;
  localparam int W = 16, N = 3, AW = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [N-1:0]  pwm_o, match_flag_o;
  logic          bottom_flag_o, falling_o;
  logic [W-1:0]  cnt_o;

  symm_pwm_timer #(.WIDTH(W), .NCH(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .match_flag_o(match_flag_o),
    .bottom_flag_o(bottom_flag_o), .cnt_o(cnt_o), .falling_o(falling_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic        sel;
    logic [2:0]  inv;
    logic [15:0] per;
    logic [15:0] c0;
    logic [15:0] c1;
    logic [15:0] c2;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 3'b000, 16'd20,  16'd5,  16'd10, 16'd0},
    '{1'b0, 3'b010, 16'd20,  16'd15, 16'd4,  16'd19},
    '{1'b0, 3'b101, 16'd3,   16'd1,  16'd2,  16'd0},
    '{1'b1, 3'b000, 16'd100, 16'd12, 16'd3,  16'd11},
    '{1'b1, 3'b110, 16'd9,   16'd8,  16'd1,  16'd7},
    '{1'b0, 3'b111, 16'd64,  16'd63, 16'd32, 16'd1}
  };

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    tick = 1'b0; rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int top, zeros, mx, expv;
    int hi [N];
    logic [15:0] cv [N];
    logic p;

    for (int v = 0; v < 6; v++) begin
      do_reset();
      check("R1 count", cnt_o, 0);
      check("R1 pwm", pwm_o, 0);
      check("R1 flags", {match_flag_o, bottom_flag_o}, 0);
      wr(0, W'({VEC[v].inv, VEC[v].sel}));
      wr(1, VEC[v].per);
      wr(3, VEC[v].c0);
      wr(4, VEC[v].c1);
      wr(5, VEC[v].c2);
      cv[0] = VEC[v].c0; cv[1] = VEC[v].c1; cv[2] = VEC[v].c2;
      top = VEC[v].sel ? int'(VEC[v].c0) : int'(VEC[v].per);
      tick = 1'b1;
      repeat (2 * top + 2) cyc();
      zeros = 0; mx = 0;
      for (int i = 0; i < N; i++) hi[i] = 0;
      for (int k = 0; k < 2 * top; k++) begin
        cyc();
        for (int i = 0; i < N; i++) if (pwm_o[i]) hi[i]++;
        if (cnt_o == 0) zeros++;
        if (int'(cnt_o) > mx) mx = int'(cnt_o);
      end
      check("R3/R4 peak equals TOP", mx, top);
      check("R3 one bottom tick per cycle", zeros, 1);
      for (int i = 0; i < N; i++) begin
        if (VEC[v].sel && i == 0) expv = 0;
        else begin
          expv = 2 * int'(cv[i]);
          if (VEC[v].inv[i]) expv = 2 * top - expv;
        end
        check((VEC[v].sel && i == 0) ? "R11 shared channel low" :
              (VEC[v].inv[i] ? "R7 inverted duty" : "R6 duty"), hi[i], expv);
      end
      check("R8/R11 match flags", match_flag_o, 3'b111);
      check("R9 bottom flag", bottom_flag_o, 1);
    end

    do_reset();
    wr(1, 16'd10); wr(3, 16'd2); wr(4, 16'd4); wr(5, 16'd8);
    tick = 1'b1;
    repeat (5) cyc();
    check("R3 climb from zero", cnt_o, 5);
    tick = 1'b0;
    p = pwm_o[1];
    repeat (3) cyc();
    check("R2 count held", cnt_o, 5);
    check("R2 pwm held", pwm_o[1], p);

    tick = 1'b1;
    while (!(cnt_o == 9 && !falling_o)) cyc();
    cyc();
    check("R3 reaches TOP", cnt_o, 10);
    check("R3 rising at TOP", falling_o, 0);
    cyc();
    check("R3 turns after one tick", cnt_o, 9);
    check("R3 falling after TOP", falling_o, 1);

    while (!(cnt_o == 3 && !falling_o)) cyc();
    wr(1, 16'd6);
    mx = 0;
    while (cnt_o != 0) begin
      cyc();
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end
    check("R5 current cycle keeps old TOP", mx, 10);
    mx = 0;
    do begin
      cyc();
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end while (cnt_o != 0);
    check("R5 new TOP from next bottom", mx, 6);
    check("R8 flags set", match_flag_o, 3'b111);

    tick = 1'b0;
    p = pwm_o[1];
    wr(0, 16'b0100);
    check("R7 invert applies next cycle", pwm_o[1], !p);
    wr(0, 16'b0000);
    check("R7 invert removed", pwm_o[1], p);

    wr(2, 16'b0000);
    check("R10 zero bits keep flags", match_flag_o, 3'b111);
    check("R10 zero bits keep bottom", bottom_flag_o, 1);
    wr(2, 16'b0101);
    check("R10 selective clear", match_flag_o, 3'b101);
    check("R10 bottom cleared", bottom_flag_o, 0);
    tick = 1'b1;
    while (cnt_o != 4) cyc();
    wr(2, 16'b1100);
    check("R10 set wins over clear", match_flag_o, 3'b011);

    do_reset();
    wr(1, 16'hFFFF);
    tick = 1'b1;
    while (cnt_o != 16'hFFFF) cyc();
    check("R12 rising at max TOP", falling_o, 0);
    cyc();
    check("R12 turn without wrap", cnt_o, 16'hFFFE);
    check("R12 falling after max", falling_o, 1);
    check("R8 match at max TOP", match_flag_o, 3'b111);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule